// File: doc/BRIEF.md
# Serial Port Register Block with Receive FIFO

This block is the register side of a serial port. Software uses a byte-wide register bus to reach it. The bus has an address, a write enable with write data, and a read enable with combinational read data. Behind the bus sit the mode, baud, control, FIFO-control and port registers, a status register, a transmit data register and a receive FIFO. The line side has two strobe interfaces. Received bytes come in as `rx_valid`/`rx_data`, and each byte written for transmission goes out as a one-cycle `tx_valid`/`tx_data` pulse. The bit-level serializer and the baud timing belong to a neighbouring block.

Received bytes go into a ring FIFO, 16 entries deep by default. A 2-bit code in the FIFO-control register sets the trigger level. When the count reaches that level, the receive-full status flag is raised, and the receive interrupt is raised too if it is enabled. Status flags are cleared only when software writes a zero to them. Reading the status register while transmit is enabled sets the transmit flags again.

Register offsets, in bus address units:

| Offset | Register | Access |
|---|---|---|
| 0x0 | mode | read/write |
| 0x1 | baud | read/write |
| 0x2 | control | read/write |
| 0x3 | tx data | write only |
| 0x4 | status | read/write |
| 0x5 | rx data | read only, pops |
| 0x6 | FIFO control | read/write |
| 0x7 | FIFO count | read only |
| 0x8 | port | read/write |

Control register bits: bit 7 is transmit interrupt enable, bit 6 is receive interrupt enable, bit 5 is transmit enable and bit 4 is receive enable.

Top module: `serial_fifo_regs`

## Requirements
- R1: The receive FIFO holds DEPTH (16) bytes. A byte that arrives while the FIFO is full is dropped and the FIFO is left unchanged. A read of offset 0x7 returns the current byte count.
- R2: A byte on `rx_valid`/`rx_data` is stored only while control bit 4 is 1. Otherwise it is ignored.
- R3: A read of offset 0x5 returns the oldest stored byte and removes it, so bytes come out in arrival order. A read of 0x5 with the FIFO empty returns 0 and changes nothing.
- R4: FIFO-control bits 7:6 set the trigger level: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. After reset the code is 0. When a push leaves the count at or above the level, status bit 1 (receive full) is set.
- R5: When a pop leaves the count below the trigger level, status bit 1 is cleared.
- R6: A write to offset 0x6 with bit 1 set empties the FIFO, sets the count to 0 and clears status bit 1. A byte arriving in the same cycle is dropped.
- R7: `rx_irq` is set together with status bit 1 when control bit 6 is 1. It is cleared by a control write with bit 6 at 0, or by a status write with bit 1 or bit 0 at 0. A clear wins over a set in the same cycle.
- R8: The status register at offset 0x4 holds transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. All other bits read 0. Writing 0 to one of these bits clears that flag, and writing 1 leaves it unchanged.
- R9: A write to offset 0x3 drives `tx_valid` high for the single next cycle, with `tx_data` set to the written byte, and clears transmit-empty.
- R10: After a status read while control bit 5 is 1, transmit-empty and transmit-end are both set. While control bit 5 is 0, a status read changes neither flag.
- R11: Values are masked before they are stored: mode with 0x7B, control with 0xFA, port with 0xF3. Baud keeps all 8 bits.
- R12: After reset the registers read as follows: mode 0x00, baud 0xFF, control 0x20, status 0x60, FIFO control 0x00, count 0, port 0x00. Both interrupts are low.
- R13: On every control write, `tx_irq` takes the value of bit 7 of the written data.
- R14: Offsets 0x9 to 0xF read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (4) | Register offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W (8) | Register write data |
| rd_en | input | 1 | Register read strobe; pop and status side effects occur at the clock edge |
| rd_data | output | DATA_W (8) | Combinational read data for `addr` |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DATA_W (8) | Received byte |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | DATA_W (8) | Byte to transmit |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bound checker watches several rules on every cycle:
- the FIFO count never exceeds its depth, and a full FIFO keeps its count when a byte is offered and there is no pop or flush;
- the receive interrupt rises only in the cycle after a received strobe, and drops after each of the write kinds that clear it;
- every transmit pulse matches an earlier write, both in timing and in data;
- `tx_irq` follows control bit 7.

Other behaviour needs whole register sequences, so the directed scenarios cover it: the order in which bytes are popped, the trigger thresholds for all four codes, flushing, the write-zero clearing of status, the transmit flags being set again by a status read, the register masks, the reset values and the unmapped offsets.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   // register offsets
   localparam int unsigned OFF_MODE   = 0;
   localparam int unsigned OFF_BAUD   = 1;
   localparam int unsigned OFF_CTRL   = 2;
   localparam int unsigned OFF_TXD    = 3;
   localparam int unsigned OFF_STATUS = 4;
   localparam int unsigned OFF_RXD    = 5;
   localparam int unsigned OFF_FCTL   = 6;
   localparam int unsigned OFF_FCNT   = 7;
   localparam int unsigned OFF_PORT   = 8;

   // status bit positions
   localparam int unsigned ST_TEND = 6;
   localparam int unsigned ST_TDE  = 5;
   localparam int unsigned ST_BRK  = 4;
   localparam int unsigned ST_RDF  = 1;
   localparam int unsigned ST_DR   = 0;

   // control bit positions
   localparam int unsigned CT_TXIE = 7;
   localparam int unsigned CT_RXIE = 6;
   localparam int unsigned CT_TXEN = 5;
   localparam int unsigned CT_RXEN = 4;

   localparam int unsigned FC_FLUSH = 1;

   localparam logic [7:0] MASK_MODE = 8'h7B;
   localparam logic [7:0] MASK_CTRL = 8'hFA;
   localparam logic [7:0] MASK_PORT = 8'hF3;
   localparam logic [7:0] RST_BAUD  = 8'hFF;
   localparam logic [7:0] RST_CTRL  = 8'h20;

   typedef struct packed {
      logic tend;
      logic tde;
      logic brk;
      logic rdf;
      logic dr;
   } sfr_flags_t;

   function automatic int unsigned trig_level(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction
endpackage

// File: rtl/sfr_rx_fifo.sv
module sfr_rx_fifo #(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 16,
   parameter bit CLEAR_STORAGE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic                         pop,
   input  logic                         flush,
   input  logic [DATA_W-1:0]            din,
   output logic [DATA_W-1:0]            dout,
   output logic [$clog2(DEPTH+1)-1:0]   cnt,
   output logic                         empty,
   output logic                         push_ok,
   output logic                         pop_ok
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] mem [DEPTH];
   logic              full;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push & ~full & ~flush;
   assign pop_ok  = pop & ~empty & ~flush;
   assign cnt     = cnt_q;
   assign dout    = mem[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (CLEAR_STORAGE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[i] <= '0;
            else if (push_ok && wr_ptr == PTR_W'(i))
               mem[i] <= din;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PTR_W'(i))
               mem[i] <= din;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end
endmodule

// File: rtl/sfr_status.sv
module sfr_status
   import sfr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_wr,
   input  logic              st_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ctrl_wr,
   input  logic              tx_en,
   input  logic              rx_ie,
   input  logic              tx_wr,
   input  logic              rdf_set,
   input  logic              rdf_clr,
   input  logic              flush,
   output sfr_flags_t        flags,
   output logic              rx_irq
);
   sfr_flags_t f_q, f_d;
   logic       irq_q, irq_d;

   always_comb begin
      f_d = f_q;
      // status read re-arms the transmit flags when transmit is enabled
      if (st_rd && tx_en) begin
         f_d.tend = 1'b1;
         f_d.tde  = 1'b1;
      end
      if (tx_wr) f_d.tde = 1'b0;
      if (rdf_set) f_d.rdf = 1'b1;
      if (rdf_clr || flush) f_d.rdf = 1'b0;
      // software write-zero clears win over any set
      if (st_wr) begin
         if (!wdata[ST_TEND]) f_d.tend = 1'b0;
         if (!wdata[ST_TDE])  f_d.tde  = 1'b0;
         if (!wdata[ST_BRK])  f_d.brk  = 1'b0;
         if (!wdata[ST_RDF])  f_d.rdf  = 1'b0;
         if (!wdata[ST_DR])   f_d.dr   = 1'b0;
      end
   end

   always_comb begin
      irq_d = irq_q;
      if (rdf_set && rx_ie) irq_d = 1'b1;
      if (ctrl_wr && !wdata[CT_RXIE]) irq_d = 1'b0;
      if (st_wr && (!wdata[ST_RDF] || !wdata[ST_DR])) irq_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q   <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
         irq_q <= 1'b0;
      end else begin
         f_q   <= f_d;
         irq_q <= irq_d;
      end
   end

   assign flags  = f_q;
   assign rx_irq = irq_q;
endmodule

// File: rtl/serial_fifo_regs.sv
module serial_fifo_regs
   import sfr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              rx_irq,
   output logic              tx_irq
);
   localparam int CNT_W = $clog2(DEPTH+1);

   if (DATA_W < 8) begin : g_bad_data
      $error("serial_fifo_regs: DATA_W must be at least 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("serial_fifo_regs: ADDR_W must be at least 4");
   end
   if (DEPTH < 14 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("serial_fifo_regs: DEPTH must be a power of two of at least 14");
   end

   // address decode
   logic hit_mode, hit_baud, hit_ctrl, hit_txd, hit_st, hit_rxd, hit_fctl, hit_port;
   assign hit_mode = (addr == ADDR_W'(OFF_MODE));
   assign hit_baud = (addr == ADDR_W'(OFF_BAUD));
   assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
   assign hit_txd  = (addr == ADDR_W'(OFF_TXD));
   assign hit_st   = (addr == ADDR_W'(OFF_STATUS));
   assign hit_rxd  = (addr == ADDR_W'(OFF_RXD));
   assign hit_fctl = (addr == ADDR_W'(OFF_FCTL));
   assign hit_port = (addr == ADDR_W'(OFF_PORT));

   // configuration registers
   logic [DATA_W-1:0] mode_q, baud_q, ctrl_q, fctl_q, port_q;
   logic              tx_irq_q, tx_valid_q;
   logic [DATA_W-1:0] tx_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= '0;
         baud_q     <= DATA_W'(RST_BAUD);
         ctrl_q     <= DATA_W'(RST_CTRL);
         fctl_q     <= '0;
         port_q     <= '0;
         tx_irq_q   <= 1'b0;
         tx_valid_q <= 1'b0;
         tx_data_q  <= '0;
      end else begin
         tx_valid_q <= 1'b0;
         if (wr_en) begin
            if (hit_mode) mode_q <= wr_data & DATA_W'(MASK_MODE);
            if (hit_baud) baud_q <= wr_data;
            if (hit_ctrl) begin
               ctrl_q   <= wr_data & DATA_W'(MASK_CTRL);
               tx_irq_q <= wr_data[CT_TXIE];
            end
            if (hit_fctl) fctl_q <= wr_data;
            if (hit_port) port_q <= wr_data & DATA_W'(MASK_PORT);
            if (hit_txd) begin
               tx_valid_q <= 1'b1;
               tx_data_q  <= wr_data;
            end
         end
      end
   end

   // receive FIFO
   logic              push_ok, pop_ok, fifo_empty, flush;
   logic [DATA_W-1:0] fifo_dout;
   logic [CNT_W-1:0]  fifo_cnt;

   assign flush = wr_en & hit_fctl & wr_data[FC_FLUSH];

   sfr_rx_fifo #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (rx_valid & ctrl_q[CT_RXEN]),
      .pop    (rd_en & hit_rxd),
      .flush  (flush),
      .din    (rx_data),
      .dout   (fifo_dout),
      .cnt    (fifo_cnt),
      .empty  (fifo_empty),
      .push_ok(push_ok),
      .pop_ok (pop_ok)
   );

   // trigger comparison on the count after this cycle's push/pop
   logic [CNT_W:0] trig_lvl, cnt_after;
   logic           rdf_set, rdf_clr;

   assign trig_lvl  = (CNT_W+1)'(trig_level(fctl_q[7:6]));
   assign cnt_after = {1'b0, fifo_cnt} + (CNT_W+1)'(push_ok) - (CNT_W+1)'(pop_ok);
   assign rdf_set   = push_ok & (cnt_after >= trig_lvl);
   assign rdf_clr   = pop_ok & (cnt_after < trig_lvl);

   sfr_flags_t flags;

   sfr_status #(.DATA_W(DATA_W)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .st_wr  (wr_en & hit_st),
      .st_rd  (rd_en & hit_st),
      .wdata  (wr_data),
      .ctrl_wr(wr_en & hit_ctrl),
      .tx_en  (ctrl_q[CT_TXEN]),
      .rx_ie  (ctrl_q[CT_RXIE]),
      .tx_wr  (wr_en & hit_txd),
      .rdf_set(rdf_set),
      .rdf_clr(rdf_clr),
      .flush  (flush),
      .flags  (flags),
      .rx_irq (rx_irq)
   );

   // read mux
   logic [DATA_W-1:0] status_word;
   always_comb begin
      status_word          = '0;
      status_word[ST_TEND] = flags.tend;
      status_word[ST_TDE]  = flags.tde;
      status_word[ST_BRK]  = flags.brk;
      status_word[ST_RDF]  = flags.rdf;
      status_word[ST_DR]   = flags.dr;
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         ADDR_W'(OFF_MODE):   rd_data = mode_q;
         ADDR_W'(OFF_BAUD):   rd_data = baud_q;
         ADDR_W'(OFF_CTRL):   rd_data = ctrl_q;
         ADDR_W'(OFF_STATUS): rd_data = status_word;
         ADDR_W'(OFF_RXD):    rd_data = fifo_empty ? '0 : fifo_dout;
         ADDR_W'(OFF_FCTL):   rd_data = fctl_q;
         ADDR_W'(OFF_FCNT):   rd_data = DATA_W'(fifo_cnt);
         ADDR_W'(OFF_PORT):   rd_data = port_q;
         default:             rd_data = '0;
      endcase
   end

   assign tx_valid = tx_valid_q;
   assign tx_data  = tx_data_q;
   assign tx_irq   = tx_irq_q;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
   import sfr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          addr,
   input logic                       wr_en,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       rd_en,
   input logic                       rx_valid,
   input logic                       rx_irq,
   input logic                       tx_irq,
   input logic                       tx_valid,
   input logic [DATA_W-1:0]          tx_data,
   input logic [$clog2(DEPTH+1)-1:0] cnt
);
   localparam int CNT_W = $clog2(DEPTH+1);

   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(DEPTH) && rx_valid && !(rd_en && addr == ADDR_W'(OFF_RXD))
       && !(wr_en && addr == ADDR_W'(OFF_FCTL))) |=> cnt == CNT_W'(DEPTH));

   assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> $past(rx_valid));

   assert_ctrl_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_CTRL) && !wr_data[CT_RXIE]) |=> !rx_irq);

   assert_status_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_STATUS) && !(wr_data[ST_RDF] && wr_data[ST_DR]))
      |=> !rx_irq);

   assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ($past(wr_en && addr == ADDR_W'(OFF_TXD)) && tx_data == $past(wr_data)));

   assert_tx_irq_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_CTRL)) |=> tx_irq == $past(wr_data[CT_TXIE]));
endmodule

bind serial_fifo_regs sfr_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .DEPTH (DEPTH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rx_valid(rx_valid),
   .rx_irq  (rx_irq),
   .tx_irq  (tx_irq),
   .tx_valid(tx_valid),
   .tx_data (tx_data),
   .cnt     (fifo_cnt)
);

// File: tb/serial_fifo_regs_tb.sv
module serial_fifo_regs_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       rx_irq, tx_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   serial_fifo_regs u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic rdf_chk(input string req, input logic exp);
      logic [7:0] v;
      rd(4'h4, v);
      chk(req, {7'b0, v[1]}, {7'b0, exp});
   endtask

   task automatic t_reset;
      rd_chk("R12 mode", 4'h0, 8'h00);
      rd_chk("R12 baud", 4'h1, 8'hFF);
      rd_chk("R12 ctrl", 4'h2, 8'h20);
      rd_chk("R12 fifoctl", 4'h6, 8'h00);
      rd_chk("R12 count", 4'h7, 8'h00);
      rd_chk("R12 port", 4'h8, 8'h00);
      rd_chk("R12 status", 4'h4, 8'h60);
      chk("R12 irqs", {6'b0, rx_irq, tx_irq}, 8'h00);
   endtask

   task automatic t_masks;
      wr(4'h0, 8'hFF); rd_chk("R11 mode mask", 4'h0, 8'h7B);
      wr(4'h8, 8'hFF); rd_chk("R11 port mask", 4'h8, 8'hF3);
      wr(4'h1, 8'h5A); rd_chk("R11 baud", 4'h1, 8'h5A);
      wr(4'h2, 8'hFF); rd_chk("R11 ctrl mask", 4'h2, 8'hFA);
      chk("R13 tx_irq set", {7'b0, tx_irq}, 8'h01);
      wr(4'h2, 8'h30);
      chk("R13 tx_irq clear", {7'b0, tx_irq}, 8'h00);
   endtask

   task automatic t_tx;
      wr(4'h3, 8'hA5);
      chk("R9 tx_valid", {7'b0, tx_valid}, 8'h01);
      chk("R9 tx_data", tx_data, 8'hA5);
      @(negedge clk);
      chk("R9 tx_valid one cycle", {7'b0, tx_valid}, 8'h00);
      rd_chk("R9 tde cleared", 4'h4, 8'h40);
      rd_chk("R10 tde rearmed", 4'h4, 8'h60);
      wr(4'h2, 8'h10);
      wr(4'h3, 8'h3C);
      rd_chk("R10 txen off", 4'h4, 8'h40);
      rd_chk("R10 no rearm", 4'h4, 8'h40);
      wr(4'h2, 8'h30);
      rd_chk("R10 rearm read", 4'h4, 8'h40);
      rd_chk("R10 rearmed", 4'h4, 8'h60);
   endtask

   task automatic t_status;
      wr(4'h4, 8'hDF); rd_chk("R8 clear tde only", 4'h4, 8'h40);
      wr(4'h4, 8'hFF); rd_chk("R8 write ones", 4'h4, 8'h60);
      wr(4'h4, 8'h00); rd_chk("R8 clear all", 4'h4, 8'h00);
      rd_chk("R8 after rearm", 4'h4, 8'h60);
   endtask

   task automatic t_fifo;
      for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
      rd_chk("R1 count full", 4'h7, 8'd16);
      rdf_chk("R4 level 1 flag", 1'b1);
      push(8'hEE);
      rd_chk("R1 drop when full", 4'h7, 8'd16);
      for (int i = 0; i < 16; i++) rd_chk("R3 pop order", 4'h5, 8'(i * 3 + 1));
      rd_chk("R1 count empty", 4'h7, 8'd0);
      rdf_chk("R5 flag clear on empty", 1'b0);
      rd_chk("R3 empty read", 4'h5, 8'h00);
      rd_chk("R3 empty unchanged", 4'h7, 8'd0);
   endtask

   task automatic t_trigger;
      wr(4'h6, 8'h80);
      for (int i = 0; i < 7; i++) push(8'h10);
      rdf_chk("R4 level 8 below", 1'b0);
      push(8'h11);
      rdf_chk("R4 level 8 reached", 1'b1);
      rd_chk("R5 pop value", 4'h5, 8'h10);
      rdf_chk("R5 below after pop", 1'b0);
      wr(4'h6, 8'hC2);
      rd_chk("R6 flush count", 4'h7, 8'd0);
      for (int i = 0; i < 13; i++) push(8'h20);
      rdf_chk("R4 level 14 below", 1'b0);
      push(8'h21);
      rdf_chk("R4 level 14 reached", 1'b1);
      wr(4'h6, 8'h42);
      rd_chk("R6 flush count 2", 4'h7, 8'd0);
      rdf_chk("R6 flag cleared", 1'b0);
      rd_chk("R6 fifoctl stored", 4'h6, 8'h42);
      for (int i = 0; i < 3; i++) push(8'h30);
      rdf_chk("R4 level 4 below", 1'b0);
      push(8'h31);
      rdf_chk("R4 level 4 reached", 1'b1);
      wr(4'h6, 8'h02);
   endtask

   task automatic t_irq;
      wr(4'h2, 8'h70);
      wr(4'h6, 8'h40);
      for (int i = 0; i < 3; i++) push(8'h40);
      chk("R7 irq below level", {7'b0, rx_irq}, 8'h00);
      push(8'h41);
      chk("R7 irq at level", {7'b0, rx_irq}, 8'h01);
      wr(4'h4, 8'hFE);
      chk("R7 status bit0 clears irq", {7'b0, rx_irq}, 8'h00);
      rdf_chk("R8 rdf kept by write 1", 1'b1);
      push(8'h42);
      chk("R7 irq again", {7'b0, rx_irq}, 8'h01);
      wr(4'h2, 8'h30);
      chk("R7 ctrl clears irq", {7'b0, rx_irq}, 8'h00);
      wr(4'h6, 8'h02);
   endtask

   task automatic t_rxen;
      wr(4'h2, 8'h20);
      push(8'h55); push(8'h56);
      rd_chk("R2 disabled ignores", 4'h7, 8'd0);
      wr(4'h2, 8'h30);
      push(8'h57);
      rd_chk("R2 enabled accepts", 4'h7, 8'd1);
      rd_chk("R2 byte value", 4'h5, 8'h57);
   endtask

   task automatic t_unmapped;
      wr(4'hC, 8'h55);
      rd_chk("R14 read unmapped", 4'hC, 8'h00);
      rd_chk("R14 read 0xF", 4'hF, 8'h00);
      rd_chk("R14 mode unchanged", 4'h0, 8'h7B);
      rd_chk("R14 baud unchanged", 4'h1, 8'h5A);
      rd_chk("R14 port unchanged", 4'h8, 8'hF3);
      rd_chk("R14 ctrl unchanged", 4'h2, 8'h30);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masks();
      t_tx();
      t_status();
      t_fifo();
      t_trigger();
      t_irq();
      t_rxen();
      t_unmapped();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule